// File: doc/BRIEF.md
# Word-Count Address Splitter

This unit takes a signed byte address and splits it into a signed word offset (the address divided by the word size, rounded toward minus infinity) and a byte selector (the low address bits). It works over several cycles, like a microcoded datapath. When a run starts, the unit pushes its small evaluation stack down. It then shifts a working copy of the address right once per loop pass, and fills the vacated top bit with the sign of the address.

A loop counter controls the pass count. The counter is preset to minus (passes × bytes per word) and rises by bytes per word on every pass. The loop ends on the pass whose increment carries out of the word. The original address is kept in a save register, and the last cycle masks it down to the byte selector. With the defaults (32-bit word, 4 bytes per word, 2 passes) a run takes four busy cycles. After the last cycle, the one-cycle `done` pulse appears together with the final stack values.

Top module: `wc_split`

## Requirements
- R1: After synchronous reset, `a_out`, `b_out` and `c_out` are zero and `busy` and `done` are low.
- R2: On the clock edge where `start` is sampled high while idle, `c_out` takes the `b_in` value. It keeps that value through the run and after it.
- R3: When `done` is high, `a_out` equals `a_in` (as captured at start) shifted right arithmetically by 2, with sign-filled top bits.
- R4: When `done` is high, `b_out` equals the captured `a_in` ANDed with 0x3.
- R5: `done` rises on the 5th rising edge counted from the edge that samples `start`. That edge counts as the 1st, so `busy` is high for exactly 4 cycles and the loop makes exactly two shift passes.
- R6: `done` is high for exactly one cycle per run.
- R7: `busy` is high from the cycle after start until the final edge. Any `start` pulse or input change while busy has no effect on the result and does not begin a new run.
- R8: While idle with `start` low, `a_out`, `b_out` and `c_out` hold their values whatever `a_in` and `b_in` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| a_in | input | 32 | Byte address (top of stack before the run) |
| b_in | input | 32 | Second stack entry before the run |
| a_out | output | 32 | Stack top: word offset after a run |
| b_out | output | 32 | Second entry: byte selector after a run |
| c_out | output | 32 | Third entry: previous second entry |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, results valid |

## Verification
The design has three internal faults that show at the ports. A wrong counter preset or step, or a carry taken on the wrong pass, changes the number of shift passes. That shows on the `done` pulse, which arrives early or late. It also shows in `a_out`, which is then shifted by the wrong amount. A sign flag that is latched wrongly or at the wrong time corrupts only the top bits of `a_out`, so negative and most-negative addresses are the patterns that expose it. A save register that is not loaded, or is cleared too early, gives a wrong `b_out` in the `done` cycle itself. Each of these shows within five cycles of `start`.

// File: rtl/wc_pkg.sv
package wc_pkg;

    localparam int WC_WORD_W = 32;
    localparam int WC_BPW    = 4;
    localparam int WC_LOOPS  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TEST  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FIN   = 2'd3
    } wc_state_e;

    typedef struct packed {
        wc_state_e st;
        logic      neg;
    } wc_ctrl_t;

    typedef struct packed {
        logic load;
        logic save;
        logic shift;
        logic fin;
    } wc_strobe_t;

endpackage

// File: rtl/wc_loop_ctr.sv
module wc_loop_ctr #(
    parameter int W     = 32,
    parameter int BPW   = 4,
    parameter int LOOPS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic preset,
    input  logic step,
    output logic last
);
    localparam logic [W:0] STEP_V   = (W+1)'(BPW);
    localparam logic [W-1:0] PRESET = W'(-(LOOPS * BPW));

    logic [W-1:0] cnt_q;
    logic [W:0]   sum;

    assign sum  = {1'b0, cnt_q} + STEP_V;
    assign last = sum[W];

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (preset) cnt_q <= PRESET;
        else if (step)   cnt_q <= sum[W-1:0];
    end
endmodule

// File: rtl/wc_shifter.sv
module wc_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         fill,
    output logic [W-1:0] dout
);
    assign dout = {fill, din[W-1:1]};
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
    import wc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       last,
    input  logic       sign_bit,
    output wc_ctrl_t   ctrl,
    output wc_strobe_t strb
);
    wc_ctrl_t ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        strb   = '0;
        unique case (ctrl_q.st)
            ST_IDLE: if (start) begin
                strb.load = 1'b1;
                ctrl_d.st = ST_TEST;
            end
            ST_TEST: begin
                strb.save  = 1'b1;
                ctrl_d.neg = sign_bit;
                ctrl_d.st  = ST_SHIFT;
            end
            ST_SHIFT: begin
                strb.shift = 1'b1;
                if (last) ctrl_d.st = ST_FIN;
            end
            ST_FIN: begin
                strb.fin  = 1'b1;
                ctrl_d.st = ST_IDLE;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '{st: ST_IDLE, neg: 1'b0};
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/wc_split.sv
module wc_split
    import wc_pkg::*;
#(
    parameter int W     = WC_WORD_W,
    parameter int BPW   = WC_BPW,
    parameter int LOOPS = WC_LOOPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] c_out,
    output logic         busy,
    output logic         done
);
    localparam logic [W-1:0] SEL_MASK = W'(BPW - 1);

    logic [W-1:0] a_q, b_q, c_q, sav_q, b_shr;
    logic         done_q, last;
    wc_ctrl_t     ctrl;
    wc_strobe_t   strb;

    wc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last     (last),
        .sign_bit (b_q[W-1]),
        .ctrl     (ctrl),
        .strb     (strb)
    );

    wc_loop_ctr #(.W(W), .BPW(BPW), .LOOPS(LOOPS)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .preset (strb.load),
        .step   (strb.shift),
        .last   (last)
    );

    wc_shifter #(.W(W)) u_shr (
        .din  (b_q),
        .fill (ctrl.neg),
        .dout (b_shr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
            sav_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= strb.fin;
            if (strb.load) begin
                a_q <= a_in;
                b_q <= a_in;
                c_q <= b_in;
            end
            if (strb.save)  sav_q <= a_q;
            if (strb.shift) b_q   <= b_shr;
            if (strb.fin) begin
                b_q   <= sav_q & SEL_MASK;
                a_q   <= b_q;
                sav_q <= '0;
            end
        end
    end

    assign a_out = a_q;
    assign b_out = b_q;
    assign c_out = c_q;
    assign busy  = (ctrl.st != ST_IDLE);
    assign done  = done_q;
endmodule

// File: rtl/wc_split_chk.sv
module wc_split_chk #(
    parameter int W     = 32,
    parameter int BPW   = 4,
    parameter int LOOPS = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic [W-1:0] c_out,
    input logic         busy,
    input logic         done
);
    localparam int RUN_CYC = LOOPS + 2;

    logic [7:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 8'd1;
        else           busy_cnt <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done && a_out == '0)); // R1
    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        done |-> ((&a_out[W-1 -: LOOPS+1]) || !(|a_out[W-1 -: LOOPS+1]))); // R3
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (b_out <= W'(BPW - 1))); // R4
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == 8'(RUN_CYC))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_THIRD_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(c_out)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(a_out) && $stable(b_out) && $stable(c_out))); // R8
endmodule

bind wc_split wc_split_chk #(.W(W), .BPW(BPW), .LOOPS(LOOPS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .a_out (a_out),
    .b_out (b_out),
    .c_out (c_out),
    .busy  (busy),
    .done  (done)
);

// File: tb/sim_wc_split.sv
module sim_wc_split;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out, c_out;
    logic         busy, done;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_split u0 (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .b_out(b_out), .c_out(c_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk(a_out == '0, "R1 a_out", a_out, '0);
        chk(b_out == '0, "R1 b_out", b_out, '0);
        chk(c_out == '0, "R1 c_out", c_out, '0);
        chk(!busy && !done, "R1 busy/done", {30'd0, busy, done}, '0);
    endtask

    // one full run; optionally pulses start with other data while busy
    task automatic t_run(input logic [W-1:0] addr, input logic [W-1:0] second, input bit disturb);
        logic [W-1:0] exp_a, exp_b;
        int lat;
        exp_a = $unsigned($signed(addr) >>> 2);
        exp_b = addr & 32'h3;
        @(negedge clk);
        start = 1'b1; a_in = addr; b_in = second;
        @(negedge clk);
        start = 1'b0; lat = 1;
        chk(busy == 1'b1, "R7 busy after start", {31'd0, busy}, 1);
        chk(c_out == second, "R2 c_out at load", c_out, second);
        while (!done && lat < 20) begin
            if (disturb && lat == 2) begin
                start = 1'b1; a_in = ~addr; b_in = ~second;
            end else begin
                start = 1'b0;
            end
            @(negedge clk); lat++;
        end
        start = 1'b0;
        chk(lat == 5, "R5 latency", lat, 5);
        chk(a_out == exp_a, "R3 word offset", a_out, exp_a);
        chk(b_out == exp_b, "R4 byte select", b_out, exp_b);
        chk(c_out == second, "R2 c_out at done", c_out, second);
        chk(!busy, "R7 idle at done", {31'd0, busy}, 0);
        @(negedge clk);
        chk(!done, "R6 done one cycle", {31'd0, done}, 0);
        if (disturb)
            chk(!busy, "R7 start while busy ignored", {31'd0, busy}, 0);
    endtask

    task automatic t_hold();
        logic [W-1:0] pa, pb, pc;
        pa = a_out; pb = b_out; pc = c_out;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a_in = $urandom; b_in = $urandom;
        end
        chk(a_out == pa, "R8 a_out held", a_out, pa);
        chk(b_out == pb, "R8 b_out held", b_out, pb);
        chk(c_out == pc, "R8 c_out held", c_out, pc);
    endtask

    initial begin
        t_reset();
        t_run(32'h1234_5677, 32'hAAAA_0001, 1'b0);
        t_run(32'hFFFF_FFF9, 32'h0000_00FF, 1'b0);
        t_run(32'h0000_0000, 32'h5555_5555, 1'b0);
        t_run(32'h8000_0000, 32'h0BAD_F00D, 1'b0);
        t_run(32'h7FFF_FFFF, 32'h0000_0002, 1'b0);
        t_run(32'hFFFF_FFFF, 32'h1357_9BDF, 1'b0);
        t_run(32'hC000_0006, 32'h2468_ACE0, 1'b1);
        t_hold();
        t_run(32'h0000_000B, 32'h0000_0003, 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule